// File: doc/BRIEF.md
# Latch-Switched Character Bank Translator

This block turns a 14-bit video fetch address in the pattern area (0x0000 to 0x1FFF) into a 1 KB character-ROM page number. Eight slots each hold an 8-bit low byte and an 8-bit high byte. Together they form a 16-bit bank value. A control register can replace every high byte with one shared 5-bit block value. In the 2K and 1K layouts it can also make slots 2 and 3 read the values of slots 0 and 1.

The external two-bit mapping mode picks one of four window sizes. In the 4K layout each half takes its bank from a slot chosen by a snooping latch. The latch moves when the renderer fetches certain tile rows. The build parameter `LATCH_SNOOP` decides whether the latches follow fetches at all. Writes come from the CPU side as an address/data strobe. The page output is combinational from the registered state and the current fetch address.

Top module: `chr_bank_xlat`

## Requirements
- R1: After reset, every low and high byte is 0, slot aliasing and block mode are off, and the lower and upper latches hold 0 and 4.
- R2: A write with wr_addr[15:12] = 0x9 stores wr_data in the low byte of slot wr_addr[2:0]. Address bits 11:3 are ignored, and nothing changes while wr_en is low.
- R3: A write with wr_addr[15:12] = 0xA stores wr_data in the high byte of slot wr_addr[2:0].
- R4: A write with wr_addr[15:12] = 0xD and wr_addr[2:0] = 3 loads the control fields: bit 7 turns slot aliasing on, bit 5 = 0 selects block mode, and bits 4:0 give the block value. A write to any other 0xD address changes nothing.
- R5: In mode 0 the page is (bank of slot 0) × 8 + vaddr[12:10].
- R6: In mode 1 the page is (bank of the slot held by the latch for half vaddr[12]) × 4 + vaddr[11:10].
- R7: In mode 2 the page is (bank of slot 2·vaddr[12:11]) × 2 + vaddr[10].
- R8: In mode 3 the page is the bank of slot vaddr[12:10].
- R9: In block mode a slot's bank is {3'b000, block value, low byte} instead of {high byte, low byte}.
- R10: With aliasing on and mode 2 or 3, slots 2 and 3 take the bank values of slots 0 and 1. In modes 0 and 1 aliasing has no effect.
- R11: With fetch strobe vstb high and vaddr[13] = 0, an address whose bits 11:0 fall in 0xFD8 to 0xFDF sets the latch for half vaddr[12] to 0 (lower) or 4 (upper). An address in 0xFE8 to 0xFEF sets it to 2 (lower) or 6 (upper). The new value applies from the next cycle, so the triggering fetch still uses the old one.
- R12: The latches hold when vstb is low, when vaddr[13] is 1, or when the address is outside both trigger ranges.
- R13: With LATCH_SNOOP = 0, the latches stay at 0 and 4 regardless of fetches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| vstb | input | 1 | Video fetch strobe |
| vaddr | input | 14 | Video fetch address |
| map_mode | input | 2 | Window layout: 0 = 8K, 1 = 4K, 2 = 2K, 3 = 1K |
| page | output | 19 | 1 KB page number |

## Verification
The assertions assume that vstb marks one fetch per cycle and that vaddr is steady around the clock edge. They also assume map_mode changes only between fetches. The stimulus follows these rules: it changes inputs only on the falling edge, drops the strobe after a single cycle, and writes registers only while no fetch is strobed.

The checks on latch legality and latch holding depend on a reset applied before the first fetch. The bench holds reset low for several cycles before it sends any stimulus.

// File: rtl/chr_xlat_pkg.sv
package chr_xlat_pkg;
  localparam int DW     = 8;
  localparam int BLK_W  = 5;
  localparam int SLOTS  = 8;
  localparam int VA_W   = 14;
  localparam int BANK_W = 2 * DW;
  localparam int PAGE_W = BANK_W + 3;

  typedef enum logic [1:0] {
    MAP_8K = 2'd0,
    MAP_4K = 2'd1,
    MAP_2K = 2'd2,
    MAP_1K = 2'd3
  } map_mode_e;

  typedef struct packed {
    logic             alias_en;
    logic             block_on;
    logic [BLK_W-1:0] block_val;
  } bank_ctl_t;
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
  import chr_xlat_pkg::*;
#(
  parameter int N_SLOT = SLOTS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [15:0]                 wr_addr,
  input  logic [DW-1:0]               wr_data,
  output logic [N_SLOT-1:0][DW-1:0]   lo_q,
  output logic [N_SLOT-1:0][DW-1:0]   hi_q,
  output bank_ctl_t                   ctl_q
);
  localparam int IDX_W = $clog2(N_SLOT);

  logic      sel_lo, sel_hi, sel_ctl;
  bank_ctl_t ctl_d;

  assign sel_lo  = wr_en && (wr_addr[15:12] == 4'h9);
  assign sel_hi  = wr_en && (wr_addr[15:12] == 4'hA);
  assign sel_ctl = wr_en && (wr_addr[15:12] == 4'hD) && (wr_addr[2:0] == 3'd3);

  always_comb begin
    ctl_d = ctl_q;
    if (sel_ctl) begin
      ctl_d.alias_en  = wr_data[7];
      ctl_d.block_on  = ~wr_data[5];
      ctl_d.block_val = wr_data[BLK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  for (genvar i = 0; i < N_SLOT; i++) begin : g_slot
    logic lo_we, hi_we;
    assign lo_we = sel_lo && (wr_addr[IDX_W-1:0] == IDX_W'(i));
    assign hi_we = sel_hi && (wr_addr[IDX_W-1:0] == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end else begin
        if (lo_we) lo_q[i] <= wr_data;
        if (hi_we) hi_q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/chr_fetch_latch.sv
module chr_fetch_latch
  import chr_xlat_pkg::*;
#(
  parameter bit SNOOP = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            vstb,
  input  logic [VA_W-1:0] vaddr,
  output logic [2:0]      lat_lo,
  output logic [2:0]      lat_hi
);
  if (SNOOP) begin : g_snoop
    logic       hit_d, hit_e, upd;
    logic [2:0] new_val, lo_d, hi_d;

    assign hit_d   = (vaddr[11:3] == 9'h1FB);
    assign hit_e   = (vaddr[11:3] == 9'h1FD);
    assign upd     = vstb && !vaddr[13] && (hit_d || hit_e);
    assign new_val = {vaddr[12], hit_e, 1'b0};

    always_comb begin
      lo_d = lat_lo;
      hi_d = lat_hi;
      if (upd && !vaddr[12]) lo_d = new_val;
      if (upd &&  vaddr[12]) hi_d = new_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lat_lo <= 3'd0;
        lat_hi <= 3'd4;
      end else begin
        lat_lo <= lo_d;
        lat_hi <= hi_d;
      end
    end
  end else begin : g_fixed
    assign lat_lo = 3'd0;
    assign lat_hi = 3'd4;
  end
endmodule

// File: rtl/chr_page_sel.sv
module chr_page_sel
  import chr_xlat_pkg::*;
#(
  parameter int N_SLOT = SLOTS
) (
  input  logic [1:0]                  map_mode,
  input  logic [VA_W-1:0]             vaddr,
  input  logic [N_SLOT-1:0][DW-1:0]   lo_q,
  input  logic [N_SLOT-1:0][DW-1:0]   hi_q,
  input  bank_ctl_t                   ctl_q,
  input  logic [2:0]                  lat_lo,
  input  logic [2:0]                  lat_hi,
  output logic [PAGE_W-1:0]           page
);
  localparam int IDX_W = $clog2(N_SLOT);

  logic [N_SLOT-1:0][BANK_W-1:0] bank;
  logic                          fold;
  logic [IDX_W-1:0]              idx;
  logic [BANK_W-1:0]             sel;

  assign fold = map_mode[1] && ctl_q.alias_en;

  for (genvar i = 0; i < N_SLOT; i++) begin : g_bank
    localparam bit CAN_FOLD = (i == 2) || (i == 3);
    localparam int ALT      = CAN_FOLD ? i - 2 : i;
    logic [DW-1:0] lo_s, hi_s;
    assign lo_s = (CAN_FOLD && fold) ? lo_q[ALT] : lo_q[i];
    assign hi_s = (CAN_FOLD && fold) ? hi_q[ALT] : hi_q[i];
    assign bank[i] = ctl_q.block_on ? {{(DW-BLK_W){1'b0}}, ctl_q.block_val, lo_s}
                                    : {hi_s, lo_s};
  end

  always_comb begin
    unique case (map_mode)
      MAP_8K:  idx = '0;
      MAP_4K:  idx = vaddr[12] ? lat_hi : lat_lo;
      MAP_2K:  idx = {vaddr[12:11], 1'b0};
      default: idx = vaddr[12:10];
    endcase
    sel = bank[idx];
    unique case (map_mode)
      MAP_8K:  page = {sel, vaddr[12:10]};
      MAP_4K:  page = {1'b0, sel, vaddr[11:10]};
      MAP_2K:  page = {2'b00, sel, vaddr[10]};
      default: page = {3'b000, sel};
    endcase
  end
endmodule

// File: rtl/chr_bank_xlat.sv
module chr_bank_xlat
  import chr_xlat_pkg::*;
#(
  parameter bit LATCH_SNOOP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              vstb,
  input  logic [13:0]       vaddr,
  input  logic [1:0]        map_mode,
  output logic [18:0]       page
);
  logic [SLOTS-1:0][DW-1:0] lo_q, hi_q;
  bank_ctl_t                ctl_q;
  logic [2:0]               lat_lo, lat_hi;
  logic                     alias_en, block_on;

  assign alias_en = ctl_q.alias_en;
  assign block_on = ctl_q.block_on;

  chr_bank_regs #(.N_SLOT(SLOTS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .lo_q(lo_q), .hi_q(hi_q), .ctl_q(ctl_q)
  );

  chr_fetch_latch #(.SNOOP(LATCH_SNOOP)) u_latch (
    .clk(clk), .rst_n(rst_n), .vstb(vstb), .vaddr(vaddr),
    .lat_lo(lat_lo), .lat_hi(lat_hi)
  );

  chr_page_sel #(.N_SLOT(SLOTS)) u_sel (
    .map_mode(map_mode), .vaddr(vaddr), .lo_q(lo_q), .hi_q(hi_q),
    .ctl_q(ctl_q), .lat_lo(lat_lo), .lat_hi(lat_hi), .page(page)
  );
endmodule

// File: rtl/chr_bank_xlat_chk.sv
module chr_bank_xlat_chk #(
  parameter bit SNOOP = 1'b1
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_addr,
  input logic        vstb,
  input logic [13:0] vaddr,
  input logic [1:0]  map_mode,
  input logic [18:0] page,
  input logic [2:0]  lat_lo,
  input logic [2:0]  lat_hi,
  input logic        alias_en,
  input logic        block_on
);
  // R11: lower latch only ever names slot 0 or 2
  assert_lat_lo_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_lo == 3'd0) || (lat_lo == 3'd2));
  // R11: upper latch only ever names slot 4 or 6
  assert_lat_hi_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_hi == 3'd4) || (lat_hi == 3'd6));
  // R11: lower 0xFEx fetch moves lower latch to 2
  assert_fe_trigger_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (SNOOP && vstb && vaddr[13:12] == 2'b00 && vaddr[11:4] == 8'hFE && !vaddr[3] == 1'b0)
    |=> (lat_lo == 3'd2));
  // R12: no strobe, no latch movement
  assert_lat_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !vstb |=> ($stable(lat_lo) && $stable(lat_hi)));
  // R4: control writes to other offsets leave the fields alone
  assert_ctl_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[15:12] == 4'hD && wr_addr[2:0] != 3'd3)
    |=> ($stable(alias_en) && $stable(block_on)));
  // R5: 8K window keeps the fetch offset in the page low bits
  assert_mode0_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (map_mode == 2'd0) |-> (page[2:0] == vaddr[12:10]));
  // R9: block mode limits a 1K page to 13 bits
  assert_block_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (map_mode == 2'd3 && block_on) |-> (page[18:13] == 6'd0));

  if (!SNOOP) begin : g_fixed_chk
    // R13: fixed latches without snooping
    assert_fixed_latch_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (lat_lo == 3'd0) && (lat_hi == 3'd4));
  end
endmodule

bind chr_bank_xlat chr_bank_xlat_chk #(.SNOOP(LATCH_SNOOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .vstb(vstb), .vaddr(vaddr), .map_mode(map_mode), .page(page),
  .lat_lo(lat_lo), .lat_hi(lat_hi), .alias_en(alias_en), .block_on(block_on)
);

// File: tb/chr_bank_xlat_bench.sv
`timescale 1ns/1ps
module chr_bank_xlat_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        vstb;
  logic [13:0] vaddr;
  logic [1:0]  map_mode;
  logic [18:0] page, page_fx;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  chr_bank_xlat #(.LATCH_SNOOP(1'b1)) u_chr_bank_xlat (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vstb(vstb), .vaddr(vaddr), .map_mode(map_mode), .page(page)
  );

  chr_bank_xlat #(.LATCH_SNOOP(1'b0)) u_chr_bank_xlat_fixed (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .vstb(vstb), .vaddr(vaddr), .map_mode(map_mode), .page(page_fx)
  );

  // {mode, vaddr, expected page}; slot i holds low 0x20+i, high i+1
  localparam logic [34:0] VECS [10] = '{
    {2'd0, 14'h0000, 19'h00900},
    {2'd0, 14'h1C00, 19'h00907},
    {2'd1, 14'h0400, 19'h00481},
    {2'd1, 14'h1800, 19'h01492},
    {2'd2, 14'h0C00, 19'h00645},
    {2'd2, 14'h1000, 19'h00A48},
    {2'd2, 14'h1C00, 19'h00E4D},
    {2'd3, 14'h0800, 19'h00322},
    {2'd3, 14'h1400, 19'h00625},
    {2'd3, 14'h1FFF, 19'h00827}
  };

  task automatic check(input logic [18:0] act, input logic [18:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input logic [1:0] m, input logic [13:0] va,
                      input logic [18:0] exp, input string tag);
    @(negedge clk);
    map_mode = m; vaddr = va;
    #2;
    check(page, exp, tag);
  endtask

  task automatic fetch(input logic [13:0] va);
    @(negedge clk);
    vaddr = va; vstb = 1'b1;
    @(negedge clk);
    vstb = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    vstb = 1'b0; vaddr = '0; map_mode = 2'd3;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: cleared banks after reset
    look(2'd3, 14'h1C00, 19'h0, "R1 1K after reset");
    look(2'd1, 14'h1C00, 19'h3, "R1 4K after reset");

    for (int i = 0; i < 8; i++) begin
      wr(16'h9000 + 16'(i), 8'h20 + 8'(i));
      wr(16'hA000 + 16'(i), 8'(i + 1));
    end

    // R5 R6 R7 R8, reset latches 0/4 (R1)
    for (int k = 0; k < 10; k++)
      look(VECS[k][34:33], VECS[k][32:19], VECS[k][18:0], "R5/R6/R7/R8 table");

    // R2: ignored middle address bits, and no write without strobe
    wr(16'h9FF9, 8'h55);
    look(2'd3, 14'h0400, 19'h00255, "R2 low write");
    @(negedge clk); wr_en = 1'b0; wr_addr = 16'h9001; wr_data = 8'hEE;
    @(negedge clk);
    look(2'd3, 14'h0400, 19'h00255, "R2 no write when idle");

    // R3
    wr(16'hA002, 8'h09);
    look(2'd3, 14'h0800, 19'h00922, "R3 high write");

    // R9 / R4 block mode on then off
    wr(16'hD003, 8'h1A);
    look(2'd3, 14'h0800, 19'h01A22, "R9 block value");
    wr(16'hD003, 8'h3A);
    look(2'd3, 14'h0800, 19'h00922, "R4 block off");
    wr(16'hD000, 8'h9A);
    look(2'd3, 14'h0800, 19'h00922, "R4 other offset ignored");

    // R10 aliasing
    wr(16'hD003, 8'hA0);
    look(2'd3, 14'h0800, 19'h00120, "R10 slot2 alias");
    look(2'd3, 14'h0C00, 19'h00255, "R10 slot3 alias");
    look(2'd3, 14'h1000, 19'h00524, "R10 slot4 untouched");
    look(2'd2, 14'h0800, 19'h00240, "R10 2K alias");
    wr(16'hD003, 8'h20);

    // R11 latch timing: old value during trigger, new after
    @(negedge clk);
    map_mode = 2'd1; vaddr = 14'h0FE8; vstb = 1'b1;
    #2; check(page, 19'h00483, "R11 trigger uses old latch");
    @(negedge clk);
    vstb = 1'b0;
    #2; check(page, 19'h0248B, "R11 lower latch to 2");
    check(page_fx, 19'h00483, "R13 fixed lower latch");

    // R10: no aliasing in 4K layout
    wr(16'hD003, 8'hA0);
    look(2'd1, 14'h0000, 19'h02488, "R10 no alias in mode 1");
    wr(16'hD003, 8'h20);

    fetch(14'h1FE8);
    look(2'd1, 14'h1000, 19'h01C98, "R11 upper latch to 6");
    #0 check(page_fx, 19'h01490, "R13 fixed upper latch");
    fetch(14'h1FD8);
    look(2'd1, 14'h1000, 19'h01490, "R11 upper latch to 4");

    // R12: latch holds for non-trigger cases
    fetch(14'h2FE8);
    look(2'd1, 14'h0000, 19'h02488, "R12 bit13 set ignored");
    @(negedge clk); vaddr = 14'h0FDA; vstb = 1'b0;
    @(negedge clk);
    look(2'd1, 14'h0000, 19'h02488, "R12 no strobe ignored");
    fetch(14'h0FF8);
    look(2'd1, 14'h0000, 19'h02488, "R12 outside range ignored");
    fetch(14'h0FDF);
    look(2'd1, 14'h0000, 19'h00480, "R11 lower latch to 0");

    finish_run();
  end
endmodule